// File: doc/BRIEF.md
# Planar Tile Charger

This block sits between a processor byte bus and a four-plane bitmap memory. A 32 KB window lets one processor byte access reach several colour planes at once. Two small I/O registers control it. The control register turns the charger on, picks the write style, and excludes individual planes. The pattern register holds one byte per plane and is loaded through a single port that steps a 2-bit slot pointer.

When the charger is on, a window write can fill every enabled plane with its pattern byte. Depending on the control register, it can instead merge the pattern into each plane through a bit mask given by the processor data. A window read can return a match mask: a 1 marks each bit position where every enabled plane equals its pattern. When the charger is off, window accesses go straight to memory unchanged.

The block drives one single-port synchronous memory port whose read data arrives one cycle after the request. It works through the enabled planes in rising index order and ends each access with a one-cycle ready pulse.

Top module: `plane_tile_charger`

## Requirements
- R1: An I/O write to offset 0xC loads the 8-bit control register and returns the pattern slot pointer to 0. Control bit 7 turns the charger on. Bit 6 set selects masked merge, and bit 6 clear selects pattern fill. Bits 3:0 exclude plane 3..0 when set.
- R2: An I/O write to offset 0xE stores the byte into the pattern slot named by the pointer, then advances the pointer modulo 4. A fifth write after a pointer reset overwrites slot 0.
- R3: An I/O read of offset 0xC or 0xE returns 0xFF on io_rdata in the same cycle.
- R4: With control bit 7 clear, a window write stores the processor byte at memory address bank*0x20000 + offset, and a window read returns the byte held there.
- R5: When the charger works on plane i, the memory address is bank*0x20000 + ((i+1) mod 4)*0x8000 + offset.
- R6: In pattern fill mode (bits 7,6 = 1,0), a window write stores pattern slot i into each enabled plane i, in rising plane order. The processor data has no effect.
- R7: In masked merge mode (bits 7,6 = 1,1), a window write turns each enabled plane into (old AND NOT data) OR (pattern AND data).
- R8: With bits 7,6 = 1,0, a window read returns NOT of the OR, over enabled planes, of (plane XOR pattern).
- R9: With bits 7,6 = 1,1, a window read returns the plain byte at bank*0x20000 + offset.
- R10: A charger access with every plane excluded writes no memory, returns 0xFF, and gives ready in the first cycle after acceptance.
- R11: Ready is a one-cycle pulse. For a fill of n planes it comes n+1 cycles after acceptance, and for a merge or compare read 2n+1 cycles after. For a plain write it comes after 2 cycles, and for a plain read after 3.
- R12: After reset the control register, all four pattern slots and the pointer are zero, so window accesses start out plain.
- R13: An access uses the control and pattern values held before the edge that accepts it. An I/O write in the same cycle, or during the access, does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 4 | I/O register offset |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| win_req | input | 1 | Window access request, sampled while idle |
| win_we | input | 1 | Window access is a write |
| win_off | input | 15 | Byte offset within the window |
| win_wdata | input | 8 | Window write data or merge mask |
| bank | input | BANK_W | Memory bank select, 128 KB per bank |
| win_ready | output | 1 | Access complete pulse |
| win_rdata | output | 8 | Window read result, valid with win_ready |
| vram_en | output | 1 | Memory request |
| vram_we | output | 1 | Memory write enable |
| vram_addr | output | BANK_W+17 | Memory byte address |
| vram_wdata | output | 8 | Memory write data |
| vram_rdata | input | 8 | Memory read data, one cycle after the request |

## Verification
A register load and the acceptance of a window access can fall in the same clock edge. The charger must then work from the control and pattern values it held before that edge. The bench provokes this by raising win_req together with an I/O write that turns the charger off, and then with a write that replaces a pattern slot. It judges the result from the memory writes it logs in its model of the memory: all four planes must still receive the old pattern bytes. The access after that must follow the new settings.

// File: rtl/plane_tile_charger.sv
module plane_tile_charger #(
  parameter int BANK_W = 2,
  localparam int VA_W = BANK_W + 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [3:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              win_req,
  input  logic              win_we,
  input  logic [14:0]       win_off,
  input  logic [7:0]        win_wdata,
  input  logic [BANK_W-1:0] bank,
  output logic              win_ready,
  output logic [7:0]        win_rdata,
  output logic              vram_en,
  output logic              vram_we,
  output logic [VA_W-1:0]   vram_addr,
  output logic [7:0]        vram_wdata,
  input  logic [7:0]        vram_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_PLAIN, S_LAT, S_WR, S_RD, S_USE, S_DONE} st_t;

  st_t              state;
  logic [7:0]       ctl_q;
  logic [3:0][7:0]  pat_q, pat_s;
  logic [1:0]       idx_q;
  logic [14:0]      off_q;
  logic [7:0]       data_q, res_q;
  logic             we_q;
  logic [BANK_W-1:0] bank_q;
  logic [3:0]       pend_q, pend_nx;
  logic [1:0]       cur;
  logic             last, ctl_hit, pat_hit, plain_acc;

  assign ctl_hit  = io_wr && io_addr == 4'hC;
  assign pat_hit  = io_wr && io_addr == 4'hE;
  assign io_rdata = (io_rd && (io_addr == 4'hC || io_addr == 4'hE)) ? 8'hFF : 8'h00;

  always_comb begin
    cur = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (pend_q[i]) cur = 2'(i);
  end
  assign pend_nx   = pend_q & ~(4'b0001 << cur);
  assign last      = pend_nx == 4'b0000;
  assign plain_acc = !ctl_q[7] || (!win_we && ctl_q[6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      pat_q <= '0;
      idx_q <= '0;
    end else if (ctl_hit) begin
      ctl_q <= io_wdata;
      idx_q <= 2'd0;
    end else if (pat_hit) begin
      pat_q[idx_q] <= io_wdata;
      idx_q        <= idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pat_s  <= '0;
      off_q  <= '0;
      data_q <= '0;
      res_q  <= '0;
      we_q   <= 1'b0;
      bank_q <= '0;
      pend_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (win_req) begin
          pat_s  <= pat_q;
          off_q  <= win_off;
          data_q <= win_wdata;
          we_q   <= win_we;
          bank_q <= bank;
          res_q  <= '0;
          pend_q <= ~ctl_q[3:0];
          if (plain_acc)                     state <= S_PLAIN;
          else if (ctl_q[3:0] == 4'hF)       state <= S_DONE;
          else if (win_we && !ctl_q[6])      state <= S_WR;
          else                               state <= S_RD;
        end
        S_PLAIN: state <= we_q ? S_DONE : S_LAT;
        S_LAT: begin
          res_q <= ~vram_rdata;
          state <= S_DONE;
        end
        S_WR: begin
          pend_q <= pend_nx;
          state  <= last ? S_DONE : S_WR;
        end
        S_RD: state <= S_USE;
        S_USE: begin
          if (!we_q) res_q <= res_q | (vram_rdata ^ pat_s[cur]);
          pend_q <= pend_nx;
          state  <= last ? S_DONE : S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign vram_en    = state == S_PLAIN || state == S_WR || state == S_RD || (state == S_USE && we_q);
  assign vram_we    = (state == S_PLAIN && we_q) || state == S_WR || (state == S_USE && we_q);
  assign vram_addr  = {bank_q, (state == S_PLAIN) ? 2'b00 : cur + 2'd1, off_q};
  assign vram_wdata = (state == S_PLAIN) ? data_q :
                      (state == S_WR)    ? pat_s[cur] :
                      ((vram_rdata & ~data_q) | (pat_s[cur] & data_q));
  assign win_ready  = state == S_DONE;
  assign win_rdata  = win_ready ? ~res_q : 8'h00;

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready);
  p_idx_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> idx_q == 2'd0);
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_hit |=> idx_q == $past(idx_q) + 2'd1);
  p_plane_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) |=> $countones(pend_q) + 1 == $countones($past(pend_q)));
  p_held_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |=> vram_addr == $past(vram_addr));

endmodule

// File: tb/plane_tile_charger_tb.sv
`timescale 1ns/1ps
module plane_tile_charger_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic io_wr = 0, io_rd = 0, win_req = 0, win_we = 0;
  logic [3:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata, win_wdata = 0, win_rdata, vram_wdata, vram_rdata;
  logic [14:0] win_off = 0;
  logic [1:0] bank = 0;
  logic win_ready, vram_en, vram_we;
  logic [18:0] vram_addr;

  int checks = 0, errors = 0;
  logic [7:0] mem [int unsigned];
  int unsigned la[$];
  logic [7:0] ld[$];
  logic [7:0] rd_q = 0;

  always #2.5 clk = ~clk;

  plane_tile_charger u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .win_req(win_req), .win_we(win_we),
    .win_off(win_off), .win_wdata(win_wdata), .bank(bank), .win_ready(win_ready),
    .win_rdata(win_rdata), .vram_en(vram_en), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata));

  assign vram_rdata = rd_q;
  always @(posedge clk) begin
    if (vram_en) begin
      if (vram_we) begin
        mem[int'(vram_addr)] = vram_wdata;
        la.push_back(int'(vram_addr));
        ld.push_back(vram_wdata);
      end else
        rd_q <= mem.exists(int'(vram_addr)) ? mem[int'(vram_addr)] : 8'h00;
    end
  end

  function automatic int unsigned paddr(int bk, int i, int off);
    return bk * 32'h20000 + (((i + 1) * 32'h8000) % 32'h20000) + off;
  endfunction
  function automatic int unsigned qaddr(int bk, int off);
    return bk * 32'h20000 + off;
  endfunction
  function automatic logic [7:0] rdm(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_w(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic set_pat(input logic [7:0] p0, p1, p2, p3);
    io_w(4'hC, 8'h00);
    io_w(4'hE, p0); io_w(4'hE, p1); io_w(4'hE, p2); io_w(4'hE, p3);
  endtask

  task automatic win_op(input bit we, input logic [14:0] off, input logic [7:0] d,
                        input logic [1:0] bk, output logic [7:0] rd, output int cyc);
    la.delete(); ld.delete();
    @(negedge clk); win_req = 1; win_we = we; win_off = off; win_wdata = d; bank = bk;
    @(negedge clk); win_req = 0; cyc = 1;
    while (!win_ready && cyc < 50) begin @(negedge clk); cyc++; end
    rd = win_rdata;
    @(negedge clk);
    chk(!win_ready, "R11 pulse", win_ready, 0);
  endtask

  task automatic t_reset;
    logic [7:0] r; int c;
    win_op(1, 15'h0100, 8'h3C, 2'd0, r, c);
    chk(la.size() == 1 && la[0] == qaddr(0, 'h100) && ld[0] == 8'h3C, "R12 plain after reset", la.size(), 1);
    io_w(4'hC, 8'h80);
    win_op(1, 15'h0200, 8'hFF, 2'd0, r, c);
    chk(la.size() == 4 && ld[0] == 0 && ld[1] == 0 && ld[2] == 0 && ld[3] == 0, "R12 patterns zero", la.size(), 4);
  endtask

  task automatic t_regs;
    logic [7:0] r; int c;
    io_w(4'hC, 8'h00);
    io_w(4'hE, 8'h11); io_w(4'hE, 8'h22); io_w(4'hE, 8'h33); io_w(4'hE, 8'h44); io_w(4'hE, 8'h55);
    io_w(4'hC, 8'h80);
    win_op(1, 15'h0010, 8'h00, 2'd0, r, c);
    chk(ld.size() == 4 && ld[0] == 8'h55 && ld[1] == 8'h22 && ld[2] == 8'h33 && ld[3] == 8'h44, "R2 wrap", ld.size() > 0 ? ld[0] : 0, 8'h55);
    io_w(4'hC, 8'h80);
    io_w(4'hE, 8'hAA);
    win_op(1, 15'h0011, 8'h00, 2'd0, r, c);
    chk(ld.size() == 4 && ld[0] == 8'hAA && ld[1] == 8'h22, "R1 pointer reset", ld.size() > 0 ? ld[0] : 0, 8'hAA);
    @(negedge clk); io_rd = 1; io_addr = 4'hC; #1;
    chk(io_rdata == 8'hFF, "R3 control read", io_rdata, 8'hFF);
    io_addr = 4'hE; #1;
    chk(io_rdata == 8'hFF, "R3 pattern read", io_rdata, 8'hFF);
    @(negedge clk); io_rd = 0;
  endtask

  task automatic t_plain;
    logic [7:0] r; int c;
    io_w(4'hC, 8'h00);
    win_op(1, 15'h1234, 8'h5A, 2'd1, r, c);
    chk(la.size() == 1 && la[0] == qaddr(1, 'h1234) && ld[0] == 8'h5A, "R4 plain write", la.size() > 0 ? la[0] : 0, qaddr(1, 'h1234));
    chk(c == 2, "R11 plain write time", c, 2);
    win_op(0, 15'h1234, 8'h00, 2'd1, r, c);
    chk(r == 8'h5A, "R4 plain read", r, 8'h5A);
    chk(c == 3, "R11 plain read time", c, 3);
  endtask

  task automatic t_fill;
    logic [7:0] r; int c;
    set_pat(8'h81, 8'h42, 8'h24, 8'h18);
    io_w(4'hC, 8'h82);
    win_op(1, 15'h0777, 8'hC3, 2'd2, r, c);
    chk(la.size() == 3, "R6 plane count", la.size(), 3);
    if (la.size() == 3) begin
      chk(la[0] == paddr(2, 0, 'h777) && ld[0] == 8'h81, "R5 R6 plane0", la[0], paddr(2, 0, 'h777));
      chk(la[1] == paddr(2, 2, 'h777) && ld[1] == 8'h24, "R5 R6 plane2", la[1], paddr(2, 2, 'h777));
      chk(la[2] == paddr(2, 3, 'h777) && ld[2] == 8'h18, "R5 R6 plane3", la[2], paddr(2, 3, 'h777));
    end
    chk(c == 4, "R11 fill time", c, 4);
  endtask

  task automatic t_merge;
    logic [7:0] r; int c;
    logic [7:0] old [4] = '{8'hF0, 8'h3C, 8'h00, 8'hA5};
    logic [7:0] pt [4] = '{8'h0F, 8'hFF, 8'h55, 8'h77};
    for (int i = 0; i < 4; i++) mem[paddr(0, i, 'h400)] = old[i];
    set_pat(pt[0], pt[1], pt[2], pt[3]);
    io_w(4'hC, 8'hC8);
    win_op(1, 15'h0400, 8'h0F, 2'd0, r, c);
    for (int i = 0; i < 3; i++)
      chk(rdm(paddr(0, i, 'h400)) == ((old[i] & 8'hF0) | (pt[i] & 8'h0F)), "R7 merge",
          rdm(paddr(0, i, 'h400)), (old[i] & 8'hF0) | (pt[i] & 8'h0F));
    chk(rdm(paddr(0, 3, 'h400)) == old[3], "R7 excluded plane", rdm(paddr(0, 3, 'h400)), old[3]);
    chk(c == 7, "R11 merge time", c, 7);
  endtask

  task automatic t_cmp;
    logic [7:0] r, e; int c;
    logic [7:0] pv [4] = '{8'hF0, 8'hF3, 8'h12, 8'hF0};
    logic [7:0] pt [4] = '{8'hF1, 8'hF0, 8'h00, 8'hF0};
    for (int i = 0; i < 4; i++) mem[paddr(1, i, 'h2A)] = pv[i];
    set_pat(pt[0], pt[1], pt[2], pt[3]);
    io_w(4'hC, 8'h84);
    win_op(0, 15'h002A, 8'h00, 2'd1, r, c);
    e = ~((pv[0] ^ pt[0]) | (pv[1] ^ pt[1]) | (pv[3] ^ pt[3]));
    chk(r == e, "R8 compare mask", r, e);
    chk(la.size() == 0, "R8 no writes", la.size(), 0);
    chk(c == 7, "R11 compare time", c, 7);
    set_pat(pv[0], pv[1], 8'h00, pv[3]);
    io_w(4'hC, 8'h84);
    win_op(0, 15'h002A, 8'h00, 2'd1, r, c);
    chk(r == 8'hFF, "R8 full match", r, 8'hFF);
  endtask

  task automatic t_mread;
    logic [7:0] r; int c;
    mem[qaddr(0, 'h55)] = 8'h9E;
    io_w(4'hC, 8'hC0);
    win_op(0, 15'h0055, 8'h00, 2'd0, r, c);
    chk(r == 8'h9E && la.size() == 0, "R9 plain read in merge mode", r, 8'h9E);
  endtask

  task automatic t_none;
    logic [7:0] r; int c;
    io_w(4'hC, 8'h8F);
    win_op(1, 15'h0066, 8'h77, 2'd0, r, c);
    chk(la.size() == 0 && c == 1, "R10 no planes write", c, 1);
    win_op(0, 15'h0066, 8'h00, 2'd0, r, c);
    chk(r == 8'hFF && c == 1, "R10 no planes read", r, 8'hFF);
  endtask

  task automatic t_same;
    logic [7:0] r; int c;
    set_pat(8'h01, 8'h02, 8'h03, 8'h04);
    io_w(4'hC, 8'h80);
    la.delete(); ld.delete();
    @(negedge clk); win_req = 1; win_we = 1; win_off = 15'h0099; win_wdata = 8'hEE; bank = 0;
    io_wr = 1; io_addr = 4'hC; io_wdata = 8'h00;
    @(negedge clk); win_req = 0; io_wr = 0; c = 1;
    while (!win_ready && c < 50) begin @(negedge clk); c++; end
    chk(la.size() == 4 && ld[0] == 8'h01 && ld[3] == 8'h04, "R13 old control used", la.size(), 4);
    io_w(4'hE, 8'h00);
    win_op(1, 15'h0099, 8'hEE, 2'd0, r, c);
    chk(la.size() == 1 && ld[0] == 8'hEE, "R13 new control next", la.size(), 1);
    io_w(4'hC, 8'h80);
    la.delete(); ld.delete();
    @(negedge clk); win_req = 1; win_we = 1; win_off = 15'h009A; bank = 0;
    io_wr = 1; io_addr = 4'hE; io_wdata = 8'h99;
    @(negedge clk); win_req = 0; io_wr = 0; c = 1;
    while (!win_ready && c < 50) begin @(negedge clk); c++; end
    chk(la.size() == 4 && ld[0] == 8'h00, "R13 old pattern used", ld.size() > 0 ? ld[0] : 0, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_plain();
    t_fill();
    t_merge();
    t_cmp();
    t_mread();
    t_none();
    t_same();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule